// File: doc/BRIEF.md
# Address-Range Protection Rule Table

This block is the access firewall placed in front of a multi-port memory controller. It holds twenty programmable rules. Each rule names a window of the address space in 1 MiB steps, a window of transaction IDs, the set of controller ports it covers, which security states it admits, and whether a hit means accept or reject. Each check request carries a port number, a transaction ID, a secure/non-secure flag and address bits [31:20]. The block compares the request with every rule at once. The lowest-numbered matching rule decides the outcome. If no rule matches, a per-port default bit decides.

Software never writes a rule directly. It fills three shared holding registers (address window, ID window, rule attributes). It then writes the select register with a rule number and a commit command. A fetch command does the reverse: it copies a stored rule back into the holding registers so software can read it. The register bus is a plain synchronous write strobe with a combinational read mux.

Top module: `addr_rule_fw`

## Requirements
- R1: The table has exactly 20 rules, indexed 0 to 19. Select register offset 0 holds the rule number in bits [4:0]. Writing it with bit 5 set commits the holding registers into that rule. Writing it with bit 6 set and bit 5 clear loads that rule into the holding registers. Bit 5 wins when both bits are set. Commands naming rule 20 to 31 do nothing. The select register reads back the last rule number written, with the command bits reading 0.
- R2: The address window register is at offset 1: low bound in [11:0], high bound in [23:12]. The ID window register is at offset 2 with the same layout. The attribute register is at offset 3: security in [1:0], valid in [2], port mask in [12:3], result in [13]. The default register is at offset 4, one bit per port in [9:0]. Reads return the addressed register in the same cycle, with unused bits and unused offsets reading 0.
- R3: After a fetch, the holding registers show the stored rule's contents from the next cycle on.
- R4: A rule matches only when all of these hold: valid is 1; the port's mask bit is set; the ID lies inside the ID window, both ends included; the address bits [31:20] lie inside the address window, both ends included; and the security field admits the request. Security bit 0 admits secure requests and bit 1 admits non-secure requests, so 3 admits both.
- R5: When several rules match, the lowest-numbered one decides. A result of 0 accepts and 1 rejects.
- R6: A request that matches no rule takes the default bit of its port (0 accepts, 1 rejects). A port number of 10 or more matches no rule and is always rejected.
- R7: The decision appears one clock after a valid request. The decision-valid output is high for exactly that cycle, and the reject output is 0 whenever decision-valid is 0.
- R8: Reset makes every rule invalid and clears the default, select and holding registers, so every request on ports 0 to 9 is accepted.
- R9: A request in the same cycle as a commit is judged by the table as it stood before the commit. The new rule applies from the next request cycle on.
- R10: Committing an all-zero rule into every index leaves only the default register in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWData | input | 24 | Register write data |
| regRData | output | 24 | Register read data for regAddr |
| chkValid | input | 1 | Check request valid |
| chkPort | input | 4 | Requesting controller port |
| chkId | input | 12 | Transaction ID |
| chkMib | input | 12 | Address bits [31:20] of the request |
| chkSecure | input | 1 | 1 for a secure request, 0 for non-secure |
| decValid | output | 1 | Decision valid, one cycle after chkValid |
| decReject | output | 1 | 1 rejects, 0 accepts |

## Verification
The two functions that can land in one cycle are a rule commit through the select register and a check request. The bench provokes this by asserting the commit write and a request on the same clock edge. The request targets an address that only the new rule covers, while the default register rejects. The decision for that request must still be a reject. An identical request one cycle later must be accepted. The fetch-and-commit pair on a single select write is judged the same way: the committed value is fetched back afterwards, and the holding registers must stay untouched.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int FW_PORTS   = 10;
  localparam int FW_PORT_W  = 4;
  localparam int FW_BOUND_W = 12;
  localparam int FW_ID_W    = 12;
  localparam int FW_SEL_W   = 5;
  localparam int FW_DATA_W  = 24;
  localparam int FW_OFF_W   = 3;
  localparam int FW_CMD_COMMIT = 5;
  localparam int FW_CMD_FETCH  = 6;
  localparam int FW_ATTR_W  = 3 + FW_PORTS + 1;

  localparam logic [FW_OFF_W-1:0] OFF_SEL  = 3'd0;
  localparam logic [FW_OFF_W-1:0] OFF_ADDR = 3'd1;
  localparam logic [FW_OFF_W-1:0] OFF_ID   = 3'd2;
  localparam logic [FW_OFF_W-1:0] OFF_ATTR = 3'd3;
  localparam logic [FW_OFF_W-1:0] OFF_DEF  = 3'd4;

  typedef struct packed {
    logic [FW_BOUND_W-1:0] addrHi;
    logic [FW_BOUND_W-1:0] addrLo;
    logic [FW_ID_W-1:0]    idHi;
    logic [FW_ID_W-1:0]    idLo;
    logic                  result;
    logic [FW_PORTS-1:0]   portMask;
    logic                  valid;
    logic [1:0]            security;
  } fwRule_t;

  typedef struct packed {
    logic                commit;
    logic                fetch;
    logic [FW_SEL_W-1:0] idx;
  } fwStrobe_t;
endpackage

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FW_OFF_W-1:0]  regAddr,
  input  logic                 regWrEn,
  input  logic [FW_DATA_W-1:0] regWData,
  output logic [FW_DATA_W-1:0] regRData,
  input  fwRule_t              ruleView,
  output fwStrobe_t            strb,
  output fwRule_t              staged,
  output logic [FW_PORTS-1:0]  defaultBits
);
  localparam int PAD_ATTR = FW_DATA_W - FW_ATTR_W;
  localparam int PAD_SEL  = FW_DATA_W - FW_SEL_W;
  localparam int PAD_DEF  = FW_DATA_W - FW_PORTS;

  logic [FW_SEL_W-1:0] selIdx;
  logic selWr;
  logic idxOk;

  assign selWr = regWrEn && (regAddr == OFF_SEL);
  assign idxOk = regWData[FW_SEL_W-1:0] < FW_SEL_W'(NUM_RULES);

  always_comb begin
    strb.idx    = regWData[FW_SEL_W-1:0];
    strb.commit = selWr && idxOk && regWData[FW_CMD_COMMIT];
    strb.fetch  = selWr && idxOk && regWData[FW_CMD_FETCH] && !regWData[FW_CMD_COMMIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx      <= '0;
      staged      <= '0;
      defaultBits <= '0;
    end else if (strb.fetch) begin
      selIdx <= regWData[FW_SEL_W-1:0];
      staged <= ruleView;
    end else if (regWrEn) begin
      unique case (regAddr)
        OFF_SEL:  selIdx <= regWData[FW_SEL_W-1:0];
        OFF_ADDR: begin
          staged.addrLo <= regWData[FW_BOUND_W-1:0];
          staged.addrHi <= regWData[2*FW_BOUND_W-1:FW_BOUND_W];
        end
        OFF_ID: begin
          staged.idLo <= regWData[FW_ID_W-1:0];
          staged.idHi <= regWData[2*FW_ID_W-1:FW_ID_W];
        end
        OFF_ATTR: begin
          staged.security <= regWData[1:0];
          staged.valid    <= regWData[2];
          staged.portMask <= regWData[3 +: FW_PORTS];
          staged.result   <= regWData[3 + FW_PORTS];
        end
        OFF_DEF:  defaultBits <= regWData[FW_PORTS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_SEL:  regRData = {{PAD_SEL{1'b0}}, selIdx};
      OFF_ADDR: regRData = {staged.addrHi, staged.addrLo};
      OFF_ID:   regRData = {staged.idHi, staged.idLo};
      OFF_ATTR: regRData = {{PAD_ATTR{1'b0}}, staged.result, staged.portMask,
                            staged.valid, staged.security};
      OFF_DEF:  regRData = {{PAD_DEF{1'b0}}, defaultBits};
      default:  regRData = '0;
    endcase
  end

  // R3
  fetch_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |=> staged == $past(ruleView));

  // R2
  default_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_DEF) |=> defaultBits == $past(regWData[FW_PORTS-1:0]));

  // R1
  cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit && strb.fetch));
endmodule

// File: rtl/fw_datapath.sv
module fw_datapath
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fwStrobe_t             strb,
  input  fwRule_t               staged,
  input  logic [FW_PORTS-1:0]   defaultBits,
  input  logic                  chkValid,
  input  logic [FW_PORT_W-1:0]  chkPort,
  input  logic [FW_ID_W-1:0]    chkId,
  input  logic [FW_BOUND_W-1:0] chkMib,
  input  logic                  chkSecure,
  output fwRule_t               ruleView,
  output logic                  decValid,
  output logic                  decReject
);
  fwRule_t [NUM_RULES-1:0] tabFlat;
  logic [NUM_RULES-1:0] hit;
  logic [NUM_RULES-1:0] winVec;
  logic anyHit, winRes, portOk, defBit, decide;

  assign portOk = chkPort < FW_PORT_W'(FW_PORTS);

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    fwRule_t entry;
    logic secOk, maskOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entry <= '0;
      else if (strb.commit && strb.idx == FW_SEL_W'(r))
        entry <= staged;
    end

    assign tabFlat[r] = entry;
    assign secOk  = chkSecure ? entry.security[0] : entry.security[1];
    assign maskOk = portOk && entry.portMask[chkPort];
    assign hit[r] = entry.valid && maskOk && secOk
                 && (chkId >= entry.idLo) && (chkId <= entry.idHi)
                 && (chkMib >= entry.addrLo) && (chkMib <= entry.addrHi);

    // R1
    commit_store_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.commit && strb.idx == FW_SEL_W'(r)) |=> entry == $past(staged));
  end

  always_comb begin
    ruleView = '0;
    for (int r = 0; r < NUM_RULES; r++)
      if (strb.idx == FW_SEL_W'(r)) ruleView = tabFlat[r];
  end

  always_comb begin
    winVec = '0;
    anyHit = 1'b0;
    winRes = 1'b0;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (hit[r]) begin
        winVec    = '0;
        winVec[r] = 1'b1;
        anyHit    = 1'b1;
        winRes    = tabFlat[r].result;
      end
    end
  end

  assign defBit = portOk ? defaultBits[chkPort] : 1'b1;
  assign decide = anyHit ? winRes : defBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decReject <= 1'b0;
    end else begin
      decValid  <= chkValid;
      decReject <= chkValid && decide;
    end
  end

  // R7
  dec_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> decValid);

  // R7
  dec_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> (!decValid && !decReject));

  // R5
  single_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winVec));

  // R5
  rule0_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && hit[0]) |=> decReject == $past(tabFlat[0].result));

  // R6
  default_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !anyHit && portOk) |=> decReject == $past(defaultBits[chkPort]));

  // R6
  bad_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !portOk) |=> decReject);
endmodule

// File: rtl/addr_rule_fw.sv
module addr_rule_fw
  import fw_pkg::*;
#(
  parameter int NUM_RULES = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FW_OFF_W-1:0]   regAddr,
  input  logic                  regWrEn,
  input  logic [FW_DATA_W-1:0]  regWData,
  output logic [FW_DATA_W-1:0]  regRData,
  input  logic                  chkValid,
  input  logic [FW_PORT_W-1:0]  chkPort,
  input  logic [FW_ID_W-1:0]    chkId,
  input  logic [FW_BOUND_W-1:0] chkMib,
  input  logic                  chkSecure,
  output logic                  decValid,
  output logic                  decReject
);
  fwStrobe_t           strb;
  fwRule_t             staged;
  fwRule_t             ruleView;
  logic [FW_PORTS-1:0] defaultBits;

  fw_ctrl #(.NUM_RULES(NUM_RULES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWData(regWData), .regRData(regRData),
    .ruleView(ruleView), .strb(strb), .staged(staged), .defaultBits(defaultBits)
  );

  fw_datapath #(.NUM_RULES(NUM_RULES)) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .staged(staged), .defaultBits(defaultBits),
    .chkValid(chkValid), .chkPort(chkPort), .chkId(chkId), .chkMib(chkMib),
    .chkSecure(chkSecure), .ruleView(ruleView),
    .decValid(decValid), .decReject(decReject)
  );
endmodule

// File: tb/sim_addr_rule_fw.sv
`timescale 1ns/1ps
module sim_addr_rule_fw;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [23:0] regWData = '0;
  logic [23:0] regRData;
  logic        chkValid = 1'b0;
  logic [3:0]  chkPort = '0;
  logic [11:0] chkId = '0;
  logic [11:0] chkMib = '0;
  logic        chkSecure = 1'b0;
  logic        decValid, decReject;

  always #2 clk = ~clk;

  addr_rule_fw u0 (.*);

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  int mLo[20], mHi[20], mIdLo[20], mIdHi[20];
  logic [1:0] mSec[20];
  logic [9:0] mMask[20];
  bit mValid[20], mRes[20];
  logic [9:0] mDef;

  int addrList[10] = '{12'h000, 12'h00F, 12'h010, 12'h01F, 12'h020,
                       12'h0FF, 12'h100, 12'h1FF, 12'h200, 12'hFFF};
  int idList[10]   = '{12'h000, 12'h07F, 12'h080, 12'h0FF, 12'h100,
                       12'h17F, 12'h180, 12'h7FF, 12'h800, 12'hFFF};

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(string req, logic [2:0] a, logic [23:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    cmp(req, regRData, exp);
  endtask

  function automatic bit expRej(int port, int id, int mib, bit sec);
    for (int r = 0; r < 20; r++) begin
      if (mValid[r] && port < 10 && mMask[r][port] && id >= mIdLo[r] && id <= mIdHi[r]
          && mib >= mLo[r] && mib <= mHi[r] && (sec ? mSec[r][0] : mSec[r][1]))
        return mRes[r];
    end
    if (port >= 10) return 1'b1;
    return mDef[port];
  endfunction

  task automatic progRule(int idx, int lo, int hi, int idLo, int idHi,
                          logic [1:0] sec, bit v, logic [9:0] mask, bit res);
    regWrite(3'd1, {hi[11:0], lo[11:0]});
    regWrite(3'd2, {idHi[11:0], idLo[11:0]});
    regWrite(3'd3, {10'd0, res, mask, v, sec});
    regWrite(3'd0, 24'h20 | idx[4:0]);
    if (idx < 20) begin
      mLo[idx] = lo; mHi[idx] = hi; mIdLo[idx] = idLo; mIdHi[idx] = idHi;
      mSec[idx] = sec; mValid[idx] = v; mMask[idx] = mask; mRes[idx] = res;
    end
  endtask

  task automatic setDef(logic [9:0] d);
    regWrite(3'd4, {14'd0, d});
    mDef = d;
  endtask

  task automatic doCheck(string req, int port, int id, int mib, bit sec);
    @(negedge clk);
    chkValid = 1'b1; chkPort = port[3:0]; chkId = id[11:0];
    chkMib = mib[11:0]; chkSecure = sec;
    @(negedge clk);
    chkValid = 1'b0;
    cmp({req, " valid"}, decValid, 1);
    cmp(req, decReject, expRej(port, id, mib, sec));
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < 12; p++)
      for (int a = 0; a < 10; a++)
        for (int i = 0; i < 10; i++)
          for (int s = 0; s < 2; s++)
            doCheck(req, p, idList[i], addrList[a], s[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 20; r++) begin
      mLo[r] = 0; mHi[r] = 0; mIdLo[r] = 0; mIdHi[r] = 0;
      mSec[r] = 0; mMask[r] = 0; mValid[r] = 0; mRes[r] = 0;
    end
    mDef = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state of all registers and the accept-all table
    for (int a = 0; a < 8; a++) regCheck("R8 reg reset", a[2:0], 24'h0);
    @(negedge clk);
    cmp("R7 idle valid", decValid, 0);
    cmp("R7 idle reject", decReject, 0);
    for (int p = 0; p < 10; p++) doCheck("R8 accept after reset", p, 12'h123, 12'h456, p[0]);

    // R2: holding register layout and masking of unused bits
    regWrite(3'd1, 24'hABC123);
    regCheck("R2 addr window", 3'd1, 24'hABC123);
    regWrite(3'd2, 24'h0FF001);
    regCheck("R2 id window", 3'd2, 24'h0FF001);
    regWrite(3'd3, 24'hFFFFFF);
    regCheck("R2 attr mask", 3'd3, 24'h003FFF);
    regWrite(3'd4, 24'hFFFFFF);
    regCheck("R2 default mask", 3'd4, 24'h0003FF);
    regWrite(3'd5, 24'hFFFFFF);
    regCheck("R2 unused offset", 3'd5, 24'h0);
    setDef(10'h000);

    // R1/R3: commit, overwrite, fetch back
    progRule(2, 12'h111, 12'h222, 12'h033, 12'h044, 2'd2, 1'b1, 10'h2A5, 1'b1);
    regWrite(3'd1, 24'h0);
    regWrite(3'd2, 24'h0);
    regWrite(3'd3, 24'h0);
    regWrite(3'd0, 24'h42);
    regCheck("R3 fetch addr", 3'd1, 24'h222111);
    regCheck("R3 fetch id", 3'd2, 24'h044033);
    regCheck("R3 fetch attr", 3'd3, {10'd0, 1'b1, 10'h2A5, 1'b1, 2'd2});
    regCheck("R1 select readback", 3'd0, 24'h02);

    // R1: both command bits commit, the holding registers stay put
    regWrite(3'd1, 24'h00F00A);
    regWrite(3'd2, 24'h0FF000);
    regWrite(3'd3, {10'd0, 1'b0, 10'h001, 1'b1, 2'd3});
    regWrite(3'd0, 24'h64);
    mLo[4] = 12'h00A; mHi[4] = 12'h00F; mIdLo[4] = 0; mIdHi[4] = 12'h0FF;
    mSec[4] = 3; mValid[4] = 1; mMask[4] = 10'h001; mRes[4] = 0;
    regWrite(3'd3, 24'h0);
    regWrite(3'd0, 24'h44);
    regCheck("R1 both bits commit", 3'd3, {10'd0, 1'b0, 10'h001, 1'b1, 2'd3});
    // R1: out-of-range fetch leaves the holding registers unchanged
    regWrite(3'd0, 24'h59);
    regCheck("R1 fetch idx 25 ignored", 3'd3, {10'd0, 1'b0, 10'h001, 1'b1, 2'd3});

    // R4/R5/R6: overlapping rule set against the bench model
    progRule(2, 0, 0, 0, 0, 2'd0, 1'b0, 10'h0, 1'b0);
    progRule(4, 0, 0, 0, 0, 2'd0, 1'b0, 10'h0, 1'b0);
    progRule(0, 12'h010, 12'h01F, 12'h000, 12'h0FF, 2'd3, 1'b1, 10'h00F, 1'b1);
    progRule(3, 12'h000, 12'h0FF, 12'h000, 12'hFFF, 2'd1, 1'b1, 10'h3FF, 1'b0);
    progRule(7, 12'h100, 12'h1FF, 12'h080, 12'h17F, 2'd2, 1'b1, 10'h0F0, 1'b1);
    progRule(19, 12'h000, 12'hFFF, 12'h800, 12'hFFF, 2'd3, 1'b1, 10'h200, 1'b0);
    setDef(10'h155);
    sweep("R4 R5 R6 rule sweep");

    // R1: commits to indices 20..31 change nothing
    for (int k = 20; k < 32; k++)
      progRule(k, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b1);
    sweep("R1 idx above 19 ignored");

    // R10: cleared table, default only
    for (int k = 0; k < 20; k++) progRule(k, 0, 0, 0, 0, 2'd0, 1'b0, 10'h0, 1'b0);
    setDef(10'h3FF);
    for (int p = 0; p < 10; p++) doCheck("R10 cleared reject all", p, 12'h000, 12'h000, 1'b1);
    setDef(10'h000);
    for (int p = 0; p < 12; p++) doCheck("R10 cleared default accept", p, 12'hFFF, 12'hFFF, 1'b0);

    // R9: check and commit on the same edge
    setDef(10'h3FF);
    regWrite(3'd1, 24'hFFF000);
    regWrite(3'd2, 24'hFFF000);
    regWrite(3'd3, {10'd0, 1'b0, 10'h3FF, 1'b1, 2'd3});
    @(negedge clk);
    regAddr = 3'd0; regWData = 24'h25; regWrEn = 1'b1;
    chkValid = 1'b1; chkPort = 4'd1; chkId = 12'h010; chkMib = 12'h020; chkSecure = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    cmp("R9 same-cycle valid", decValid, 1);
    cmp("R9 same-cycle old table", decReject, 1);
    @(negedge clk);
    chkValid = 1'b0;
    cmp("R9 next-cycle new rule", decReject, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule